// File: doc/BRIEF.md
# Fractional-Prescaled Serial Bit-Rate Tick Generator

This block turns the system clock into the timing enables used by a serial controller. A fractional stage adds a programmable step to a phase accumulator on every enabled clock and passes one prescaled pulse each time the accumulator wraps. A 13-bit down-counter then divides those pulses by a programmable reload value. The result is a base tick, which is then shaped by the selected mode.

In asynchronous mode, every base tick is issued as a 16x oversampling tick, and every sixteenth base tick also marks a bit boundary. In synchronous mode, every fourth base tick is issued as a shift-clock edge tick, and every eighth also marks a bit boundary. With no prescaling and a reload of zero, the fastest bit rate is therefore clock/16 in asynchronous mode and clock/8 in synchronous mode.

A run bit starts and stops generation, and an enable input freezes the whole chain.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset, all three tick outputs (`os_tick`, `edge_tick`, `bit_tick`) are low, and accumulator, counter and divider state is zero.
- R2: On each enabled clock while running, the 10-bit step is added to the accumulator modulo 1024. A prescaled pulse occurs when that addition carries out of bit 9. A step of 0 means bypass: a pulse occurs on every enabled clock.
- R3: On each prescaled pulse, the 13-bit counter decrements. When it is already 0, the pulse becomes a base tick and the counter loads the reload input, so base ticks are spaced by reload+1 pulses. The counter starts at 0 when running begins, so the first pulse after run rises produces a base tick.
- R4: A change of the reload input while counting does not alter the interval in progress. It only sets the interval that starts at the next underflow.
- R5: With `sync_mode`=0, `os_tick` pulses for every base tick, and `bit_tick` pulses on every 16th base tick. `edge_tick` stays low.
- R6: With `sync_mode`=1, `edge_tick` pulses on every 4th base tick, and `bit_tick` pulses on every 8th base tick (together with an edge tick). `os_tick` stays low.
- R7: While `run`=0, accumulator, counter and divider are cleared, and no tick is issued from the following cycle on.
- R8: While `en`=0 and `run`=1, all state holds and no tick is issued. Generation then resumes where it stopped.
- R9: All ticks are registered one-cycle pulses that appear the cycle after the clock edge producing them. With step 0 and reload 0, `bit_tick` is spaced 16 clocks apart in asynchronous mode and 8 clocks apart in synchronous mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Clock enable for the whole chain; low freezes it |
| run | input | 1 | Run bit; low clears all state and ticks |
| reload | input | 13 | Reload value of the down-counter |
| step | input | 10 | Fractional step added per clock; 0 bypasses the prescaler |
| sync_mode | input | 1 | 0 = asynchronous (16x ticks), 1 = synchronous (edge ticks) |
| os_tick | output | 1 | Oversampling tick, asynchronous mode |
| edge_tick | output | 1 | Shift-clock edge tick, synchronous mode |
| bit_tick | output | 1 | Bit-boundary tick, both modes |

## Verification
The bench builds the block with its default parameters: a 13-bit counter, a 10-bit step, and final divides of 16 and 8. Because it uses small reload values and steps of 0, 256 and 300, the full 16-tick and 8-tick cycles, as well as uneven carry patterns of the accumulator, occur within a few hundred clocks. A behavioural model predicts every output on every clock. Separate interval measurements then cover the reload change mid-count, the first tick after start, and the freeze and clear behaviour.

// File: rtl/baud_pkg.sv
package baud_pkg;
    typedef enum logic {
        MODE_ASYNC = 1'b0,
        MODE_SYNC  = 1'b1
    } baud_mode_e;

    typedef struct packed {
        logic os;
        logic edge_t;
        logic bitb;
    } tick_set_t;
endpackage

// File: rtl/frac_prescaler.sv
module frac_prescaler #(
    parameter int STEP_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              run,
    input  logic [STEP_W-1:0] step,
    output logic              pulse
);
    typedef struct packed {
        logic [STEP_W-1:0] acc;
    } st_t;

    st_t             st_d, st_q;
    logic [STEP_W:0] sum;

    always_comb begin
        st_d  = st_q;
        sum   = {1'b0, st_q.acc} + {1'b0, step};
        pulse = 1'b0;
        if (!run) begin
            st_d.acc = '0;
        end else if (en) begin
            st_d.acc = sum[STEP_W-1:0];
            pulse    = (step == '0) || sum[STEP_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2
    wrap_on_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && run && pulse && step != '0) |=> st_q.acc < $past(st_q.acc));

    // R7
    acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> st_q.acc == '0);
endmodule

// File: rtl/reload_timer.sv
module reload_timer #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             run,
    input  logic             pulse,
    input  logic [CNT_W-1:0] reload,
    output logic             tick
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = 1'b0;
        if (!run) begin
            st_d.cnt = '0;
        end else if (pulse) begin
            if (st_q.cnt == '0) begin
                tick     = 1'b1;
                st_d.cnt = reload;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4
    reload_at_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && run && tick) |=> st_q.cnt == $past(reload));

    // R3
    count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && run && pulse && st_q.cnt != '0) |=> st_q.cnt == $past(st_q.cnt) - 1'b1);

    // R8
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !en) |=> st_q.cnt == $past(st_q.cnt));
endmodule

// File: rtl/tick_divider.sv
module tick_divider
    import baud_pkg::*;
#(
    parameter int OS_DIV   = 16,
    parameter int SYNC_DIV = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       base,
    input  baud_mode_e mode,
    output tick_set_t  ticks
);
    localparam int DIV_W    = $clog2(OS_DIV);
    localparam int EDGE_DIV = SYNC_DIV / 2;
    localparam logic [DIV_W-1:0] OS_LAST   = DIV_W'(OS_DIV - 1);
    localparam logic [DIV_W-1:0] SYNC_LAST = DIV_W'(SYNC_DIV - 1);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        tick_set_t        tk;
    } st_t;

    st_t              st_d, st_q;
    logic [DIV_W-1:0] last;
    logic             at_edge;

    always_comb begin
        st_d    = st_q;
        st_d.tk = '0;
        last    = (mode == MODE_SYNC) ? SYNC_LAST : OS_LAST;
        at_edge = (int'(st_q.div) % EDGE_DIV) == (EDGE_DIV - 1);
        if (!run) begin
            st_d.div = '0;
        end else if (base) begin
            st_d.div       = (st_q.div >= last) ? '0 : st_q.div + 1'b1;
            st_d.tk.bitb   = (st_q.div == last);
            st_d.tk.os     = (mode == MODE_ASYNC);
            st_d.tk.edge_t = (mode == MODE_SYNC) && at_edge;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ticks = st_q.tk;

    // R6
    sync_bit_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.tk.bitb && !st_q.tk.os) |-> st_q.tk.edge_t);
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import baud_pkg::*;
#(
    parameter int RELOAD_W = 13,
    parameter int STEP_W   = 10,
    parameter int OS_DIV   = 16,
    parameter int SYNC_DIV = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                run,
    input  logic [RELOAD_W-1:0] reload,
    input  logic [STEP_W-1:0]   step,
    input  logic                sync_mode,
    output logic                os_tick,
    output logic                edge_tick,
    output logic                bit_tick
);
    logic       pre_pulse;
    logic       base_tick;
    tick_set_t  ticks;
    baud_mode_e mode;

    assign mode = sync_mode ? MODE_SYNC : MODE_ASYNC;

    frac_prescaler #(.STEP_W(STEP_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .en(en), .run(run),
        .step(step), .pulse(pre_pulse)
    );

    reload_timer #(.CNT_W(RELOAD_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .en(en), .run(run),
        .pulse(pre_pulse), .reload(reload), .tick(base_tick)
    );

    tick_divider #(.OS_DIV(OS_DIV), .SYNC_DIV(SYNC_DIV)) u_div (
        .clk(clk), .rst_n(rst_n), .run(run),
        .base(base_tick), .mode(mode), .ticks(ticks)
    );

    assign os_tick   = ticks.os;
    assign edge_tick = ticks.edge_t;
    assign bit_tick  = ticks.bitb;

    // R5
    mode_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({os_tick, edge_tick}));

    // R7
    run_low_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !os_tick && !edge_tick && !bit_tick);

    // R8
    freeze_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !os_tick && !edge_tick && !bit_tick);
endmodule

// File: tb/sim_baud_tick_gen.sv
`timescale 1ns/1ps
module sim_baud_tick_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        run = 1'b0;
    logic [12:0] reload = '0;
    logic [9:0]  step = '0;
    logic        sync_mode = 1'b0;
    logic        os_tick, edge_tick, bit_tick;

    int    checks = 0;
    int    fails = 0;
    int    cycles = 0;
    string cur_req = "R1";

    // behavioural reference state
    int acc = 0, cnt = 0, dv = 0;
    bit exp_os = 0, exp_edge = 0, exp_bit = 0;

    always #5 clk = ~clk;

    baud_tick_gen u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .run(run), .reload(reload),
        .step(step), .sync_mode(sync_mode),
        .os_tick(os_tick), .edge_tick(edge_tick), .bit_tick(bit_tick)
    );

    always @(posedge clk) begin
        bit pulse, base;
        cycles++;
        exp_os = 0; exp_edge = 0; exp_bit = 0;
        if (!rst_n || !run) begin
            acc = 0; cnt = 0; dv = 0;
        end else if (en) begin
            pulse = (step == 0) || (acc + int'(step) >= 1024);
            acc   = (acc + int'(step)) % 1024;
            base  = 0;
            if (pulse) begin
                if (cnt == 0) begin base = 1; cnt = int'(reload); end
                else cnt = cnt - 1;
            end
            if (base) begin
                if (sync_mode) begin
                    exp_edge = (dv % 4) == 3;
                    exp_bit  = dv == 7;
                    dv = (dv >= 7) ? 0 : dv + 1;
                end else begin
                    exp_os  = 1;
                    exp_bit = dv == 15;
                    dv = (dv >= 15) ? 0 : dv + 1;
                end
            end
        end
    end

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            check(cur_req, "os_tick",   int'(os_tick),   int'(exp_os));
            check(cur_req, "edge_tick", int'(edge_tick), int'(exp_edge));
            check(cur_req, "bit_tick",  int'(bit_tick),  int'(exp_bit));
        end
    end

    initial begin
        wait (cycles > 150000);
        fails++; checks++;
        $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
        summary();
    end

    function automatic bit sel(input int which);
        case (which)
            0: return os_tick;
            1: return edge_tick;
            default: return bit_tick;
        endcase
    endfunction

    task automatic wait_tick(input int which);
        do @(negedge clk); while (!sel(which));
    endtask

    task automatic to_next(input int which, output int g);
        g = 0;
        do begin @(negedge clk); g++; end while (!sel(which) && g < 20000);
    endtask

    task automatic gap(input int which, output int g);
        wait_tick(which);
        to_next(which, g);
    endtask

    task automatic quiet(input int n, input string req);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            seen += int'(os_tick) + int'(edge_tick) + int'(bit_tick);
        end
        check(req, "ticks while stopped", seen, 0);
    endtask

    initial begin
        int g;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "os_tick at reset", int'(os_tick), 0);
        check("R1", "edge_tick at reset", int'(edge_tick), 0);
        check("R1", "bit_tick at reset", int'(bit_tick), 0);
        rst_n = 1'b1; en = 1'b1;
        @(negedge clk);

        // R9 fastest async and sync rates
        cur_req = "R9"; run = 1'b1;
        gap(2, g); check("R9", "async bit gap", g, 16);
        gap(0, g); check("R9", "async os gap", g, 1);
        sync_mode = 1'b1;
        repeat (20) @(negedge clk);
        gap(2, g); check("R9", "sync bit gap", g, 8);

        // R6 sync edge spacing
        cur_req = "R6";
        gap(1, g); check("R6", "edge gap", g, 4);
        reload = 13'd2;
        repeat (30) @(negedge clk);
        gap(1, g); check("R6", "edge gap reload 2", g, 12);

        // R5 async with reload 3
        cur_req = "R5"; sync_mode = 1'b0; reload = 13'd3;
        repeat (20) @(negedge clk);
        gap(0, g); check("R5", "os gap reload 3", g, 4);
        gap(2, g); check("R5", "bit gap reload 3", g, 64);

        // R2 fractional step
        cur_req = "R2"; reload = 13'd1; step = 10'd256;
        repeat (20) @(negedge clk);
        gap(0, g); check("R2", "os gap step 256", g, 8);
        step = 10'd300; reload = 13'd0;
        repeat (400) @(negedge clk);

        // R3 first tick after start
        cur_req = "R3"; step = 10'd0; run = 1'b0;
        repeat (3) @(negedge clk);
        reload = 13'd5; run = 1'b1;
        @(negedge clk);
        check("R3", "os on first pulse", int'(os_tick), 1);
        to_next(0, g); check("R3", "os gap reload 5", g, 6);

        // R4 reload change mid-count
        cur_req = "R4"; reload = 13'd9;
        wait_tick(0);
        to_next(0, g); check("R4", "gap reload 9", g, 10);
        reload = 13'd2;
        to_next(0, g); check("R4", "gap after change", g, 10);
        to_next(0, g); check("R4", "gap new reload", g, 3);

        // R8 freeze
        cur_req = "R8"; en = 1'b0;
        quiet(40, "R8");
        en = 1'b1;
        repeat (50) @(negedge clk);

        // R7 stop
        cur_req = "R7"; run = 1'b0;
        @(negedge clk);
        quiet(40, "R7");

        // R2 dense step with sync mode, checked per cycle
        cur_req = "R2"; run = 1'b1; sync_mode = 1'b1; step = 10'd700; reload = 13'd1;
        repeat (300) @(negedge clk);
        summary();
    end
endmodule